// File: doc/BRIEF.md
# Program Suspend and Resume Sequencer

This block is the control state machine inside a flash controller that lets a running program operation pause so that the array can be read, and then continue. Software drives three control bits as plain levels: program-mode, high-voltage-enable and suspend. It can also send an interlock write strobe. The program engine is modelled as a step counter that advances once per cycle while high voltage is on, and it completes after a fixed number of steps.

A suspend is requested by a rising edge of the suspend bit while a program runs with high voltage enabled. After a short settling period the block raises its done flag, and the array becomes readable. Reads of the block under program return a fixed garbage word and are marked invalid. The operation continues when the suspend bit is cleared. It resumes from the most recent checkpoint rather than from the step where it paused, so a suspended program can take longer in total.

Top module: `flash_pgm_suspend`

## Requirements
- R1: After reset, the block is idle with done_o=0, err_o=0, rd_ok_o=1 and step_o=0.
- R2: A 0-to-1 change of pgm_i while idle starts a program: step_o is 0 one cycle later and done_o is 0. While running, step_o advances by one on each cycle with hv_i=1 and holds on each cycle with hv_i=0.
- R3: The edge that advances step_o past STEPS-1 ends the program: the block goes idle with done_o=1, rd_ok_o=1 and step_o=0.
- R4: A suspend is recognised only on a 0-to-1 change of sus_i while pgm_i=1 and hv_i=1 during a program. A rising edge with hv_i=0, or sus_i held high with no new edge, leaves done_o=0 and rd_ok_o=0, and the program keeps running.
- R5: On the edge that recognises the request, step_o freezes. done_o and rd_ok_o rise exactly SETTLE cycles after that edge, and the block is then suspended.
- R6: A read (rd_en_i=1) returns its result one cycle later. When reads are allowed (idle, or suspended) and the block is not the one under program, rd_valid_o=1 and rd_data_o equals the block index zero-extended. Otherwise rd_valid_o=0 and rd_data_o=GARBAGE (default 16'hDEAD).
- R7: An interlock write strobe while suspended sets err_o and has no other effect: done_o stays 1 and step_o is unchanged.
- R8: While suspended, a 1-to-0 change of sus_i with hv_i=1 resumes the program on the next edge. done_o falls, and step_o rolls back to the largest multiple of CKPT that is not above it.
- R9: A 1-to-0 change of sus_i with hv_i=0 while suspended is rejected: the block stays suspended with done_o=1 and step_o unchanged, and err_o becomes 1. err_o stays set until pgm_i is 0 on a clock edge.
- R10: Clearing pgm_i while a program runs or settles aborts it: on the next edge the block is idle with done_o=1 and step_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgm_i | input | 1 | Program-mode control bit |
| hv_i | input | 1 | High-voltage-enable control bit |
| sus_i | input | 1 | Suspend control bit |
| ilk_wr_i | input | 1 | Interlock write strobe |
| blk_sel_i | input | $clog2(NBLK) | Block to program, captured at start |
| rd_en_i | input | 1 | Array read request |
| rd_blk_i | input | $clog2(NBLK) | Block addressed by the read |
| done_o | output | 1 | Done flag |
| rd_ok_o | output | 1 | Array reads currently allowed |
| err_o | output | 1 | Sticky error flag |
| step_o | output | $clog2(STEPS) | Program progress step |
| rd_valid_o | output | 1 | Read data valid for the addressed block |
| rd_data_o | output | DATA_W | Read data |

## Verification
The bench builds the block with its default values: 32 steps, checkpoints every 8 steps, a 3-cycle settle and 4 blocks. These values make every checkpoint case short enough to reach. One suspend lands exactly on step 8 and resumes at step 8. Another lands on step 13 and is rejected once before it rolls back to 8, and a third on step 7 rolls back to 0. A full run then completes from a rolled-back point, which checks that the 32-step count is exact.

// File: rtl/flash_pgm_suspend.sv
module flash_pgm_suspend #(
  parameter int STEPS  = 32,
  parameter int CKPT   = 8,
  parameter int SETTLE = 3,
  parameter int NBLK   = 4,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] GARBAGE = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_i,
  input  logic              hv_i,
  input  logic              sus_i,
  input  logic              ilk_wr_i,
  input  logic [$clog2(NBLK)-1:0] blk_sel_i,
  input  logic              rd_en_i,
  input  logic [$clog2(NBLK)-1:0] rd_blk_i,
  output logic              done_o,
  output logic              rd_ok_o,
  output logic              err_o,
  output logic [$clog2(STEPS)-1:0] step_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int SW = $clog2(STEPS);
  localparam int BW = $clog2(NBLK);
  localparam int CW = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SETTLE, S_SUSP} st_t;

  st_t           st;
  logic          pgm_q, sus_q;
  logic [SW-1:0] step;
  logic [CW-1:0] cnt;
  logic [BW-1:0] pblk;

  wire sus_rise = sus_i & ~sus_q;
  wire sus_fall = ~sus_i & sus_q;
  wire rd_good  = rd_ok_o && !(st != S_IDLE && rd_blk_i == pblk);

  assign rd_ok_o = (st == S_IDLE) || (st == S_SUSP);
  assign step_o  = step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pgm_q      <= 1'b0;
      sus_q      <= 1'b0;
      step       <= '0;
      cnt        <= '0;
      pblk       <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      pgm_q <= pgm_i;
      sus_q <= sus_i;
      if (!pgm_i) err_o <= 1'b0;
      case (st)
        S_IDLE:
          if (pgm_i && !pgm_q) begin
            st     <= S_RUN;
            step   <= '0;
            done_o <= 1'b0;
            pblk   <= blk_sel_i;
          end
        S_RUN:
          if (!pgm_i) begin
            st     <= S_IDLE;
            step   <= '0;
            done_o <= 1'b1;
          end else if (sus_rise && hv_i) begin
            st  <= S_SETTLE;
            cnt <= '0;
          end else if (hv_i) begin
            if (step == SW'(STEPS - 1)) begin
              st     <= S_IDLE;
              step   <= '0;
              done_o <= 1'b1;
            end else begin
              step <= step + 1'b1;
            end
          end
        S_SETTLE:
          if (!pgm_i) begin
            st     <= S_IDLE;
            step   <= '0;
            done_o <= 1'b1;
          end else if (cnt == CW'(SETTLE - 1)) begin
            st     <= S_SUSP;
            done_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_SUSP:
          if (!pgm_i) begin
            st   <= S_IDLE;
            step <= '0;
          end else if (sus_fall) begin
            if (hv_i) begin
              st     <= S_RUN;
              done_o <= 1'b0;
              step   <= step & ~SW'(CKPT - 1);
            end else begin
              err_o <= 1'b1;
            end
          end else if (ilk_wr_i) begin
            err_o <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
      rd_valid_o <= rd_en_i && rd_good;
      if (rd_en_i)
        rd_data_o <= rd_good ? {{(DATA_W-BW){1'b0}}, rd_blk_i} : GARBAGE;
    end
  end

  a_r4_sus_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && $past(st) == S_RUN) |-> $past(hv_i && pgm_i && sus_i && !sus_q));

  a_r5_read_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok_o && st != S_IDLE) |-> done_o);

  a_r6_valid_when_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_ok_o));

  a_r8_resume_on_ckpt: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && $past(st) == S_SUSP) |-> (int'(step) % CKPT) == 0);

  a_r9_reject_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP && pgm_i && sus_q && !sus_i && !hv_i) |=> (st == S_SUSP && err_o && done_o));

  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !pgm_i) |=> (st == S_IDLE && done_o));
endmodule

// File: tb/flash_pgm_suspend_test.sv
`timescale 1ns/1ps
module flash_pgm_suspend_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pgm = 0, hv = 0, sus = 0, ilk = 0, rd_en = 0;
  logic [1:0] blk_sel = 0, rd_blk = 0;
  logic done, rd_ok, err, rd_valid;
  logic [4:0] step;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;

  typedef struct { logic v; logic [15:0] d; string r; } rd_item_t;
  rd_item_t q[$];

  always #2.5 clk = ~clk;

  flash_pgm_suspend uut (
    .clk(clk), .rst_n(rst_n), .pgm_i(pgm), .hv_i(hv), .sus_i(sus),
    .ilk_wr_i(ilk), .blk_sel_i(blk_sel), .rd_en_i(rd_en), .rd_blk_i(rd_blk),
    .done_o(done), .rd_ok_o(rd_ok), .err_o(err), .step_o(step),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(logic [1:0] b, logic v, logic [15:0] d, string r);
    rd_item_t it;
    it.v = v; it.d = d; it.r = r;
    q.push_back(it);
    rd_en = 1; rd_blk = b;
    tick();
    rd_en = 0;
  endtask

  initial begin
    forever begin
      logic fire;
      rd_item_t it;
      @(posedge clk);
      fire = rd_en;
      #1;
      if (fire && q.size() > 0) begin
        it = q.pop_front();
        check({it.r, " valid"}, rd_valid, it.v);
        check({it.r, " data"}, rd_data, it.d);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    check("R1 done", done, 0); check("R1 err", err, 0);
    check("R1 rd_ok", rd_ok, 1); check("R1 step", step, 0);
    do_read(2, 1, 16'h0002, "R6 idle read");

    blk_sel = 1; hv = 1; pgm = 1;
    tick();
    check("R2 start step", step, 0); check("R2 start done", done, 0);
    check("R2 rd_ok low in run", rd_ok, 0);
    tick(5);
    check("R2 advance", step, 5);
    hv = 0;
    do_read(3, 0, 16'hDEAD, "R6 read while running");
    tick(2);
    check("R2 hold hv low", step, 5);
    sus = 1;
    tick(4);
    check("R4 rise without hv done", done, 0);
    check("R4 rise without hv rd_ok", rd_ok, 0);
    hv = 1;
    tick(2);
    check("R4 held high runs", step, 7); check("R4 held high done", done, 0);
    sus = 0;
    tick();
    check("R2 step", step, 8);
    sus = 1;
    tick();
    check("R5 frozen step", step, 8); check("R5 not yet", done, 0);
    tick(2);
    check("R5 not yet at 3", done, 0);
    tick();
    check("R5 done after settle", done, 1); check("R5 rd_ok", rd_ok, 1);
    do_read(1, 0, 16'hDEAD, "R6 programmed block");
    do_read(0, 1, 16'h0000, "R6 other block");
    sus = 0;
    tick();
    check("R8 resume done", done, 0); check("R8 on checkpoint", step, 8);
    tick(5);
    check("R2 step after resume", step, 13);
    sus = 1;
    tick(4);
    check("R5 suspended again", done, 1);
    hv = 0; sus = 0;
    tick();
    check("R9 rejected done", done, 1); check("R9 err", err, 1);
    check("R9 step", step, 13); check("R9 still readable", rd_ok, 1);
    hv = 1; sus = 1;
    tick();
    sus = 0;
    tick();
    check("R8 rollback 13", step, 8); check("R8 done low", done, 0);
    check("R9 err sticky", err, 1);
    tick(23);
    check("R3 not yet", done, 0); check("R3 last step", step, 31);
    tick();
    check("R3 done", done, 1); check("R3 step", step, 0); check("R3 idle", rd_ok, 1);
    pgm = 0;
    tick();
    check("R9 err cleared", err, 0);

    blk_sel = 3; pgm = 1;
    tick();
    check("R2 restart", step, 0);
    tick(7);
    sus = 1;
    tick(4);
    check("R5 suspended at 7", done, 1);
    ilk = 1;
    tick();
    ilk = 0;
    check("R7 err", err, 1); check("R7 done", done, 1); check("R7 step", step, 7);
    tick();
    check("R7 stays suspended", rd_ok, 1);
    sus = 0;
    tick();
    check("R8 rollback 7", step, 0);
    tick(4);
    check("R2 step", step, 4);
    pgm = 0;
    tick();
    check("R10 done", done, 1); check("R10 idle", rd_ok, 1); check("R10 step", step, 0);
    do_read(3, 1, 16'h0003, "R6 idle after abort");
    tick(2);
    finish_run();
  end
endmodule